// File: doc/BRIEF.md
# PLL Clock-Control Register Bank

This block holds the software-visible control state of a PLL clock generator in three byte-wide registers on a simple read/write port. The registers are a control register, a bandwidth register and a programming register, placed at three consecutive byte addresses that start at `BASE_ADDR`. The bits are cross-coupled through hardware interlocks. Depending on the state of other fields, a write to one field can be blocked, a field can be forced to a fixed value, or a field can read back masked. These interlocks keep software from putting the clock generator into an inconsistent state, such as selecting the VCO while the PLL is off.

The block takes a lock-detector status input. It synchronises that input, raises a flag on each rising edge of lock while automatic mode is on, and raises an interrupt request when that flag is enabled. The block also produces the base clock. This clock is the oscillator clock or the VCO clock, divided by two, at a 50% duty cycle. A glitch-free switch moves the base clock between the two sources whenever the select bit changes. The analog PLL, the VCO and the lock detection itself are outside this block.

Top module: `pll_ctl_bank`

## Requirements
- R1: The control register sits at `BASE_ADDR` (default 8'h5C), the bandwidth register at `BASE_ADDR`+1 and the programming register at `BASE_ADDR`+2. A read of any other address returns 8'h00, and `rdata_o` is 8'h00 whenever `rd_en_i` is low.
- R2: The register layouts are as follows.
  - Control register: interrupt enable at bit 7, lock flag at bit 6, PLL-on at bit 5, base clock select at bit 4.
  - Bandwidth register: automatic mode at bit 7, lock status at bit 6, acquisition at bit 5, crystal-loss detect at bit 4.
  - Programming register: multiplier at bits 7:4, VCO range at bits 3:0.
  - Reset values: control 8'h2F, bandwidth 8'h0F, programming 8'h66.
- R3: While automatic mode is 0, the interrupt enable is held at 0 and writes to it are ignored. In the same state, the flag bit and the lock bit read as 0.
- R4: While automatic mode is 1, writes to the acquisition bit are ignored and the bit keeps its value. The mode in force before the write decides this.
- R5: The base clock select reads 0 and cannot be set to 1 while PLL-on is 0 or the VCO range is 0. A write that sets PLL-on to 0 in the same access leaves the select at 0.
- R6: While PLL-on is 1, all writes to the programming register are ignored. While PLL-on is 0, the programming register takes the written byte.
- R7: While the base clock select is 1, a write of 0 to PLL-on is ignored and PLL-on stays 1.
- R8: The lock flag sets on a rising edge of the synchronised lock input while automatic mode is 1. A read of the control register clears it, unless a new rising edge arrives in the same cycle, in which case the set takes priority. `irq_o` is the flag ANDed with the interrupt enable.
- R9: `base_clk_o` runs at half the oscillator frequency while the select is 0 and at half the VCO frequency while it is 1. In both cases the high time equals one source period.
- R10: Bits 3:0 of the control and bandwidth registers always read as 1 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a control read clears the flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| lock_i | input | 1 | Lock-detector status, asynchronous |
| osc_clk_i | input | 1 | Oscillator clock |
| vco_clk_i | input | 1 | VCO clock |
| pll_on_o | output | 1 | PLL enable |
| auto_mode_o | output | 1 | Automatic bandwidth mode |
| acq_o | output | 1 | Acquisition mode bit |
| xtal_det_o | output | 1 | Crystal-loss detect enable |
| base_sel_o | output | 1 | Base clock select, 1 = VCO |
| mult_o | output | 4 | Multiplier field |
| vrange_o | output | 4 | VCO range field |
| irq_o | output | 1 | Lock interrupt request |
| base_clk_o | output | 1 | Divided, selected base clock |

## Verification
The bench sweeps every byte value into each register under each interlock state. This exposes several classes of fault:
- A select that latches with PLL off or with a zero range would read 1 where it must read 0.
- A PLL-on bit that a clear can drop while the select is set would leave the VCO selected with the PLL off.
- A programming register that is not frozen would read back the written byte instead of the old one.
- An acquisition lock decided on the new mode, rather than the old one, would mistrack on the write that turns automatic mode on.

The interrupt enable is read back after automatic mode is cycled off and on. A design that only masks the enable, without clearing it, would return bit 7 set. The flag is checked before and after a control read, and with lock rising while automatic mode is off. The base clock period and high time are timed on both sources, both before and after a switch. A missing divide or a stuck switch would show the wrong period.

// File: rtl/pll_bank_pkg.sv
package pll_bank_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_BW   = 2'd1,
    SEL_PROG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int OFF_CTL  = 0;
  localparam int OFF_BW   = 1;
  localparam int OFF_PROG = 2;

  // control register bits
  localparam int B_IE   = 7;
  localparam int B_FLAG = 6;
  localparam int B_ON   = 5;
  localparam int B_SEL  = 4;
  // bandwidth register bits
  localparam int B_AUTO = 7;
  localparam int B_LOCK = 6;
  localparam int B_ACQ  = 5;
  localparam int B_XLD  = 4;

  localparam logic [3:0]    LOW_ONES = 4'hF;
  localparam logic [DW-1:0] PROG_RST = 8'h66;
endpackage

// File: rtl/pll_bank_regs.sv
module pll_bank_regs
  import pll_bank_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              lock_s_i,
  input  logic              flag_i,
  output logic              ctl_rd_o,
  output logic              ie_o,
  output logic              pll_on_o,
  output logic              sel_o,
  output logic              auto_o,
  output logic              acq_o,
  output logic              xld_o,
  output logic [3:0]        mult_o,
  output logic [3:0]        vrange_o
);
  logic [ADDR_W-1:0] off;
  reg_sel_e          sel;
  logic wr_ctl, wr_bw, wr_prog;
  logic ie_q, on_q, bsel_q, auto_q, acq_q, xld_q;
  logic [3:0] mult_q, vr_q;
  logic on_d, bsel_d, ie_d;
  logic vr_nz;

  assign off = addr_i - BASE_ADDR;

  always_comb begin
    if (off == ADDR_W'(OFF_CTL))       sel = SEL_CTL;
    else if (off == ADDR_W'(OFF_BW))   sel = SEL_BW;
    else if (off == ADDR_W'(OFF_PROG)) sel = SEL_PROG;
    else                               sel = SEL_NONE;
  end

  assign wr_ctl   = wr_en_i && (sel == SEL_CTL);
  assign wr_bw    = wr_en_i && (sel == SEL_BW);
  assign wr_prog  = wr_en_i && (sel == SEL_PROG);
  assign ctl_rd_o = rd_en_i && (sel == SEL_CTL);
  assign vr_nz    = |vr_q;

  // interlocks: select pins PLL on; select needs PLL on (new value) and nonzero range
  assign on_d   = bsel_q ? 1'b1 : (wr_ctl ? wdata_i[B_ON] : on_q);
  assign bsel_d = (wr_ctl ? wdata_i[B_SEL] : bsel_q) & on_d & vr_nz;
  assign ie_d   = auto_q & (wr_ctl ? wdata_i[B_IE] : ie_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      on_q   <= 1'b1;
      bsel_q <= 1'b0;
      auto_q <= 1'b0;
      acq_q  <= 1'b0;
      xld_q  <= 1'b0;
      mult_q <= PROG_RST[7:4];
      vr_q   <= PROG_RST[3:0];
    end else begin
      ie_q   <= ie_d;
      on_q   <= on_d;
      bsel_q <= bsel_d;
      if (wr_bw) begin
        auto_q <= wdata_i[B_AUTO];
        xld_q  <= wdata_i[B_XLD];
        if (!auto_q) acq_q <= wdata_i[B_ACQ];
      end
      if (wr_prog && !on_q) begin
        mult_q <= wdata_i[7:4];
        vr_q   <= wdata_i[3:0];
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTL:  rdata_o = {ie_q & auto_q, flag_i & auto_q, on_q, bsel_q, LOW_ONES};
      SEL_BW:   rdata_o = {auto_q, lock_s_i & auto_q, acq_q, xld_q, LOW_ONES};
      SEL_PROG: rdata_o = {mult_q, vr_q};
      default:  rdata_o = '0;
    endcase
    if (!rd_en_i) rdata_o = '0;
  end

  assign ie_o     = ie_q & auto_q;
  assign pll_on_o = on_q;
  assign sel_o    = bsel_q;
  assign auto_o   = auto_q;
  assign acq_o    = acq_q;
  assign xld_o    = xld_q;
  assign mult_o   = mult_q;
  assign vrange_o = vr_q;
endmodule

// File: rtl/pll_bank_irq.sv
module pll_bank_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic auto_i,
  input  logic ie_i,
  input  logic clr_i,
  output logic lock_s_o,
  output logic flag_o,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic lock_d_q, flag_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else begin
      sync_q[0] <= lock_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lock_s_o = sync_q[SYNC_STAGES-1];
  assign rise     = lock_s_o & ~lock_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_d_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      lock_d_q <= lock_s_o;
      if (!auto_i)    flag_q <= 1'b0;
      else if (rise)  flag_q <= 1'b1;   // set beats a same-cycle read clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/pll_clk_branch.sv
// One source of the switch: divide by two, gate only while the divided clock is low.
module pll_clk_branch #(
  parameter bit RST_EN = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic clk_o
);
  logic div_q, req_s_q, en_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= 1'b0;
      req_s_q <= RST_EN;
      en_q    <= RST_EN;
    end else begin
      div_q   <= ~div_q;
      req_s_q <= req_i;
      if (div_q) en_q <= req_s_q;  // this edge takes div low
    end
  end

  assign en_o  = en_q;
  assign clk_o = div_q & en_q;
endmodule

// File: rtl/pll_clk_sel.sv
module pll_clk_sel (
  input  logic rst_ni,
  input  logic sel_i,
  input  logic osc_clk_i,
  input  logic vco_clk_i,
  output logic clk_o
);
  localparam int NSRC = 2;
  logic [NSRC-1:0] src, en, req, br_clk;

  assign src    = {vco_clk_i, osc_clk_i};
  assign req[0] = ~sel_i & ~en[1];
  assign req[1] =  sel_i & ~en[0];

  for (genvar g = 0; g < NSRC; g++) begin : g_br
    pll_clk_branch #(.RST_EN(g == 0)) u_br (
      .src_clk_i (src[g]),
      .rst_ni    (rst_ni),
      .req_i     (req[g]),
      .en_o      (en[g]),
      .clk_o     (br_clk[g])
    );
  end

  assign clk_o = |br_clk;
endmodule

// File: rtl/pll_ctl_bank.sv
module pll_ctl_bank #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h5C,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              lock_i,
  input  logic              osc_clk_i,
  input  logic              vco_clk_i,
  output logic              pll_on_o,
  output logic              auto_mode_o,
  output logic              acq_o,
  output logic              xtal_det_o,
  output logic              base_sel_o,
  output logic [3:0]        mult_o,
  output logic [3:0]        vrange_o,
  output logic              irq_o,
  output logic              base_clk_o
);
  logic lock_s, flag, ctl_rd, ie;

  pll_bank_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .lock_s_i (lock_s),
    .flag_i   (flag),
    .ctl_rd_o (ctl_rd),
    .ie_o     (ie),
    .pll_on_o (pll_on_o),
    .sel_o    (base_sel_o),
    .auto_o   (auto_mode_o),
    .acq_o    (acq_o),
    .xld_o    (xtal_det_o),
    .mult_o   (mult_o),
    .vrange_o (vrange_o)
  );

  pll_bank_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .auto_i   (auto_mode_o),
    .ie_i     (ie),
    .clr_i    (ctl_rd),
    .lock_s_o (lock_s),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  pll_clk_sel u_clk (
    .rst_ni    (rst_ni),
    .sel_i     (base_sel_o),
    .osc_clk_i (osc_clk_i),
    .vco_clk_i (vco_clk_i),
    .clk_o     (base_clk_o)
  );
endmodule

// File: rtl/pll_ctl_bank_chk.sv
module pll_ctl_bank_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h5C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [7:0]        rdata_o,
  input logic              pll_on_o,
  input logic              auto_mode_o,
  input logic              acq_o,
  input logic              base_sel_o,
  input logic [3:0]        mult_o,
  input logic [3:0]        vrange_o,
  input logic              irq_o
);
  logic [ADDR_W-1:0] off;
  assign off = addr_i - BASE_ADDR;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || off > ADDR_W'(2)) |-> rdata_o == 8'h00); // R1
  AST_MASK_NO_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && off == ADDR_W'(0) && !auto_mode_o) |-> rdata_o[7:6] == 2'b00); // R3
  AST_ACQ_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_mode_o |=> $stable(acq_o)); // R4
  AST_SEL_NEEDS_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_sel_o |-> (pll_on_o && vrange_o != 4'h0)); // R5
  AST_PROG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_on_o |=> $stable({mult_o, vrange_o})); // R6
  AST_PLL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_sel_o |=> pll_on_o); // R7
  AST_IRQ_NEEDS_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> auto_mode_o); // R8
  AST_LOW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && off <= ADDR_W'(1)) |-> rdata_o[3:0] == 4'hF); // R10
endmodule

bind pll_ctl_bank pll_ctl_bank_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/sim_pll_ctl_bank.sv
`timescale 1ns/1ps
module sim_pll_ctl_bank;
  localparam logic [7:0] BASE = 8'h5C;

  logic clk = 0, osc = 0, vco = 0, rst_n = 0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr_en = 0, rd_en = 0, lock = 0;
  logic [7:0] rdata;
  logic pll_on, auto_m, acq, xld, bsel, irq, bclk;
  logic [3:0] mult, vr;

  always #5  clk = ~clk;
  always #15 osc = ~osc;
  always #4  vco = ~vco;

  pll_ctl_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .lock_i(lock), .osc_clk_i(osc), .vco_clk_i(vco),
    .pll_on_o(pll_on), .auto_mode_o(auto_m), .acq_o(acq), .xtal_det_o(xld),
    .base_sel_o(bsel), .mult_o(mult), .vrange_o(vr), .irq_o(irq), .base_clk_o(bclk)
  );

  int n_chk = 0, n_fail = 0;
  // reference model of the register state
  logic m_ie = 0, m_flag = 0, m_on = 1, m_sel = 0, m_auto = 0, m_acq = 0, m_xld = 0;
  logic [7:0] m_prog = 8'h66;
  logic [7:0] rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    logic on_n;
    on_n   = m_sel ? 1'b1 : v[5];
    m_sel  = v[4] & on_n & (m_prog[3:0] != 0);
    m_on   = on_n;
    m_ie   = m_auto & v[7];
    do_wr(BASE, v);
  endtask

  task automatic wr_bw(input logic [7:0] v);
    if (!m_auto) m_acq = v[5];
    m_auto = v[7];
    m_xld  = v[4];
    if (!m_auto) begin m_ie = 0; m_flag = 0; end
    do_wr(BASE + 8'd1, v);
  endtask

  task automatic wr_prog(input logic [7:0] v);
    if (!m_on) m_prog = v;
    do_wr(BASE + 8'd2, v);
  endtask

  function automatic logic [7:0] exp_ctl();
    return {m_ie & m_auto, m_flag & m_auto, m_on, m_sel, 4'hF};
  endfunction

  function automatic logic [7:0] exp_bw(input logic lk);
    return {m_auto, lk & m_auto, m_acq, m_xld, 4'hF};
  endfunction

  task automatic measure(input string req, input int per, input int hi);
    realtime t0, t1, t2;
    repeat (4) @(posedge bclk);
    t0 = $realtime;
    @(negedge bclk); t1 = $realtime;
    @(posedge bclk); t2 = $realtime;
    chk(req, int'(t2 - t0), per);
    chk(req, int'(t1 - t0), hi);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset values and layout
    do_rd(BASE, rv);        chk("R2 ctl reset", rv, 8'h2F);
    do_rd(BASE + 8'd1, rv); chk("R2 bw reset", rv, 8'h0F);
    do_rd(BASE + 8'd2, rv); chk("R2 prog reset", rv, 8'h66);
    chk("R2 mult/range ports", {mult, vr}, 8'h66);
    chk("R8 irq reset", irq, 0);
    // R1 unmapped addresses
    do_rd(BASE + 8'd3, rv); chk("R1 above bank", rv, 8'h00);
    do_rd(BASE - 8'd1, rv); chk("R1 below bank", rv, 8'h00);
    #1 chk("R1 idle rdata", rdata, 8'h00);
    // R9 oscillator source after reset
    measure("R9 osc/2", 60, 30);

    // R6 frozen while PLL on
    wr_prog(8'hA5);
    do_rd(BASE + 8'd2, rv); chk("R6 write ignored with PLL on", rv, 8'h66);
    wr_ctl(8'h00);
    do_rd(BASE, rv); chk("R5 PLL off", rv, exp_ctl());
    for (int v = 0; v < 256; v++) begin
      wr_prog(8'(v));
      do_rd(BASE + 8'd2, rv); chk("R6 prog writable with PLL off", rv, m_prog);
    end
    wr_prog(8'h33);

    // R3 R5 R7 R10 control sweep in both modes
    for (int a = 0; a < 2; a++) begin
      wr_bw(a[0] ? 8'h80 : 8'h00);
      for (int v = 0; v < 256; v++) begin
        wr_ctl(8'(v));
        do_rd(BASE, rv);
        chk("R3 R5 R7 R10 ctl sweep", rv, exp_ctl());
        chk("R5 R7 sel/on ports", {bsel, pll_on}, {m_sel, m_on});
      end
    end

    // R5 zero range blocks the select
    wr_ctl(8'h00); wr_ctl(8'h00);
    wr_prog(8'h30);
    wr_ctl(8'h30);
    do_rd(BASE, rv); chk("R5 zero range", rv, exp_ctl());
    chk("R5 sel port zero range", bsel, 0);

    // R4 R10 bandwidth sweep
    for (int v = 0; v < 256; v++) begin
      wr_bw(8'(v));
      do_rd(BASE + 8'd1, rv);
      chk("R4 R10 bw sweep", rv, exp_bw(1'b0));
    end

    // R8 flag, clear on read, irq
    wr_bw(8'h80);
    wr_ctl(8'hA0);
    @(negedge clk); lock = 1;
    repeat (5) @(negedge clk);
    m_flag = 1;
    chk("R8 irq on lock rise", irq, 1);
    do_rd(BASE + 8'd1, rv); chk("R8 lock status", rv, exp_bw(1'b1));
    do_rd(BASE, rv);        chk("R8 flag visible", rv, exp_ctl());
    m_flag = 0;
    #1 chk("R8 irq cleared by read", irq, 0);
    do_rd(BASE, rv);        chk("R8 flag cleared", rv, exp_ctl());

    // R3 no flag and masked lock with auto off; enable truly cleared
    @(negedge clk); lock = 0;
    repeat (4) @(negedge clk);
    wr_bw(8'h00);
    @(negedge clk); lock = 1;
    repeat (5) @(negedge clk);
    chk("R3 no irq with auto off", irq, 0);
    do_rd(BASE + 8'd1, rv); chk("R3 lock masked", rv, exp_bw(1'b1));
    do_rd(BASE, rv);        chk("R3 ie/flag masked", rv, exp_ctl());
    wr_bw(8'h80);
    do_rd(BASE, rv);        chk("R3 ie cleared after auto off", rv, exp_ctl());
    chk("R3 irq stays low", irq, 0);

    // R9 switch to VCO and back
    wr_ctl(8'h00);
    wr_prog(8'h35);
    wr_ctl(8'h30);
    chk("R5 sel set with range", bsel, 1);
    repeat (30) @(negedge clk);
    measure("R9 vco/2", 16, 8);
    wr_ctl(8'h00);
    do_rd(BASE, rv); chk("R7 PLL held on", rv, exp_ctl());
    chk("R7 pll_on port", pll_on, 1);
    repeat (30) @(negedge clk);
    measure("R9 back to osc/2", 60, 30);

    finish_run();
  end
endmodule